// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers error events from two receive channels and a lock-loss event into sticky status bytes. Software sees each status byte together with a per-bit enable byte. A bit that is recorded but not enabled stays visible in status and does not disturb the interrupt line. One global enable decides whether the interrupt line is driven at all. When it is off, the output enable drops so that the pad floats. When it is on, the line is high while any enabled status bit is set and low otherwise.

Registers are reached through a plain single-cycle read/write port. Writes take effect at the clock edge. Read data is a combinational function of the address. Status bits clear only when 1 is written to them. A write-only command bit issues a one-cycle reset pulse to the downstream datapath and leaves every register of this block as it was. The serial bus that would carry register accesses sits outside the block.

Top module: `irq_ctrl`

## Requirements
- R1: A high on channel event input bit k (k = 0..5) sets status bit k+2 of that channel's status byte at the next clock edge. Channel A events go to the byte at 0x04 and channel B events to the byte at 0x05. The bit meanings are: 7 sync error, 6 CRC error, 5 uncorrectable ECC error, 4 correctable ECC error, 3 low-level protocol error, 2 start-of-transmission bit error.
- R2: Bit 0 of the channel A status byte is the lock-loss flag. After reset it reads 1. It sets one cycle after lock_i goes from 1 to 0, and a rise of lock_i does not set it.
- R3: Status bits are sticky. A set bit stays set after its event input returns low, until it is cleared by a write.
- R4: Writing a status byte clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an event and a clearing write for the same bit fall in the same cycle, the bit is set after that edge.
- R6: With the global enable set, irq_o is 1 exactly when some status bit is 1 and the enable bit at the same position is 1. Channel A enables are at 0x03 and channel B enables at 0x02.
- R7: With the global enable (bit 0 at 0x00) cleared, irq_oe_o and irq_o are both 0 whatever the status. With it set and no enabled status bit, irq_oe_o is 1 and irq_o is 0.
- R8: Writing 1 to bit 0 of address 0x01 makes dp_rst_o high for exactly the following cycle. Address 0x01 always reads 0x00. Enable, global-enable and status registers are unchanged by it.
- R9: Reads of unmapped addresses return 0x00. Unimplemented bits read 0: bit 1 of channel A status and enable, bits 1:0 of channel B status and enable, and bits 7:1 of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| cha_evt_i | input | 6 | Channel A error event pulses |
| chb_evt_i | input | 6 | Channel B error event pulses |
| lock_i | input | 1 | Clock lock indication, 1 = locked |
| irq_o | output | 1 | Interrupt level |
| irq_oe_o | output | 1 | Interrupt pad output enable, 0 = high impedance |
| dp_rst_o | output | 1 | One-cycle datapath reset pulse |

## Verification
The checker watches four things on every cycle: that no status bit is lost unless a 1 was written to it, that every event (including one that collides with a clear) shows up in status one cycle later, that a lock fall sets the lock-loss flag, and that the interrupt pad stays undriven while globally disabled. It also checks that each reset pulse traces back to a command write and leaves the enables untouched. The bench scenarios cover what only register reads can show: the exact bit positions, the reset value of the lock-loss flag, the partial clear, the low-driven line with nothing enabled, the zero readback of the command bit and of unmapped addresses, and the pulse lasting exactly one cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned EVT_W  = 6;

  localparam logic [REG_AW-1:0] ADDR_GEN   = 8'h00;
  localparam logic [REG_AW-1:0] ADDR_CMD   = 8'h01;
  localparam logic [REG_AW-1:0] ADDR_EN_B  = 8'h02;
  localparam logic [REG_AW-1:0] ADDR_EN_A  = 8'h03;
  localparam logic [REG_AW-1:0] ADDR_STA_A = 8'h04;
  localparam logic [REG_AW-1:0] ADDR_STA_B = 8'h05;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned     W         = 8,
  parameter logic [W-1:0]    IMPL_MASK = '1,
  parameter logic [W-1:0]    RST_VAL   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= RST_VAL[b];
        else if (set_i[b]) q <= 1'b1;  // event beats clear
        else if (clr_i[b]) q <= 1'b0;
      end
      assign q_o[b] = q;
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_fall_det.sv
module irq_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end
  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned  DW     = 8,
  parameter logic [DW-1:0] MASK_A = '1,
  parameter logic [DW-1:0] MASK_B = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_gen_i,
  input  logic          we_en_a_i,
  input  logic          we_en_b_i,
  input  logic [DW-1:0] wdata_i,
  output logic          gen_o,
  output logic [DW-1:0] en_a_o,
  output logic [DW-1:0] en_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_o  <= 1'b0;
      en_a_o <= '0;
      en_b_o <= '0;
    end else begin
      if (we_gen_i)  gen_o  <= wdata_i[0];
      if (we_en_a_i) en_a_o <= wdata_i & MASK_A;
      if (we_en_b_i) en_b_o <= wdata_i & MASK_B;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DW  = REG_DW,
  parameter int unsigned AW  = REG_AW,
  parameter int unsigned EVW = EVT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [EVW-1:0] cha_evt_i,
  input  logic [EVW-1:0] chb_evt_i,
  input  logic          lock_i,
  output logic          irq_o,
  output logic          irq_oe_o,
  output logic          dp_rst_o
);
  localparam int unsigned GAP_A = DW - EVW - 1;
  localparam int unsigned GAP_B = DW - EVW;
  localparam logic [DW-1:0] IMPL_A = {{EVW{1'b1}}, {GAP_A{1'b0}}, 1'b1};
  localparam logic [DW-1:0] IMPL_B = {{EVW{1'b1}}, {GAP_B{1'b0}}};
  localparam logic [DW-1:0] RST_A  = {{(DW-1){1'b0}}, 1'b1};

  logic          lock_fall;
  logic [DW-1:0] set_a, set_b, clr_a, clr_b;
  logic [DW-1:0] stat_a_q, stat_b_q, en_a_q, en_b_q;
  logic          gen_q, dp_rst_q;
  logic          wr_gen, wr_cmd, wr_en_a, wr_en_b, wr_sta_a, wr_sta_b;

  assign wr_gen   = reg_we_i && (reg_addr_i == ADDR_GEN);
  assign wr_cmd   = reg_we_i && (reg_addr_i == ADDR_CMD);
  assign wr_en_a  = reg_we_i && (reg_addr_i == ADDR_EN_A);
  assign wr_en_b  = reg_we_i && (reg_addr_i == ADDR_EN_B);
  assign wr_sta_a = reg_we_i && (reg_addr_i == ADDR_STA_A);
  assign wr_sta_b = reg_we_i && (reg_addr_i == ADDR_STA_B);

  irq_fall_det i_lock_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (lock_i),
    .fall_o (lock_fall)
  );

  assign set_a = {cha_evt_i, {GAP_A{1'b0}}, lock_fall};
  assign set_b = {chb_evt_i, {GAP_B{1'b0}}};
  assign clr_a = wr_sta_a ? reg_wdata_i : '0;
  assign clr_b = wr_sta_b ? reg_wdata_i : '0;

  irq_sticky_bank #(.W(DW), .IMPL_MASK(IMPL_A), .RST_VAL(RST_A)) i_sta_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_a),
    .clr_i  (clr_a),
    .q_o    (stat_a_q)
  );

  irq_sticky_bank #(.W(DW), .IMPL_MASK(IMPL_B), .RST_VAL('0)) i_sta_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_b),
    .clr_i  (clr_b),
    .q_o    (stat_b_q)
  );

  irq_cfg_regs #(.DW(DW), .MASK_A(IMPL_A), .MASK_B(IMPL_B)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_gen_i  (wr_gen),
    .we_en_a_i (wr_en_a),
    .we_en_b_i (wr_en_b),
    .wdata_i   (reg_wdata_i),
    .gen_o     (gen_q),
    .en_a_o    (en_a_q),
    .en_b_o    (en_b_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dp_rst_q <= 1'b0;
    else         dp_rst_q <= wr_cmd && reg_wdata_i[0];
  end
  assign dp_rst_o = dp_rst_q;

  assign irq_oe_o = gen_q;
  assign irq_o    = gen_q && (|(stat_a_q & en_a_q) || |(stat_b_q & en_b_q));

  always_comb begin
    unique case (reg_addr_i)
      ADDR_GEN:   reg_rdata_o = {{(DW-1){1'b0}}, gen_q};
      ADDR_EN_A:  reg_rdata_o = en_a_q;
      ADDR_EN_B:  reg_rdata_o = en_b_q;
      ADDR_STA_A: reg_rdata_o = stat_a_q;
      ADDR_STA_B: reg_rdata_o = stat_b_q;
      default:    reg_rdata_o = '0;  // includes write-only command
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DW  = REG_DW,
  parameter int unsigned AW  = REG_AW,
  parameter int unsigned EVW = EVT_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_we_i,
  input logic [AW-1:0]  reg_addr_i,
  input logic [DW-1:0]  reg_wdata_i,
  input logic [EVW-1:0] cha_evt_i,
  input logic [EVW-1:0] chb_evt_i,
  input logic           lock_i,
  input logic           irq_o,
  input logic           irq_oe_o,
  input logic           dp_rst_o,
  input logic [DW-1:0]  stat_a,
  input logic [DW-1:0]  stat_b,
  input logic [DW-1:0]  en_a,
  input logic [DW-1:0]  en_b
);
  localparam int unsigned PAD = DW - EVW;

  logic [DW-1:0] keep_a, keep_b, evt_a, evt_b;
  logic          gen_wr;
  assign keep_a = stat_a & ~((reg_we_i && reg_addr_i == ADDR_STA_A) ? reg_wdata_i : '0);
  assign keep_b = stat_b & ~((reg_we_i && reg_addr_i == ADDR_STA_B) ? reg_wdata_i : '0);
  assign evt_a  = {cha_evt_i, {PAD{1'b0}}};
  assign evt_b  = {chb_evt_i, {PAD{1'b0}}};
  assign gen_wr = reg_we_i && reg_addr_i == ADDR_CMD && reg_wdata_i[0];

  a_r3_sticky_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_a & $past(keep_a)) == $past(keep_a)));
  a_r3_sticky_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_b & $past(keep_b)) == $past(keep_b)));
  a_r5_evt_sets_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cha_evt_i) |=> ((stat_a & $past(evt_a)) == $past(evt_a)));
  a_r1_evt_sets_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chb_evt_i) |=> ((stat_b & $past(evt_b)) == $past(evt_b)));
  a_r2_lock_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_i) |=> stat_a[0]);
  a_r7_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o |-> !irq_o);
  a_r8_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_rst_o |-> $past(gen_wr));
  a_r8_cfg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_rst_o |-> ($stable(en_a) && $stable(en_b)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.DW(DW), .AW(AW), .EVW(EVW)) i_irq_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cha_evt_i   (cha_evt_i),
  .chb_evt_i   (chb_evt_i),
  .lock_i      (lock_i),
  .irq_o       (irq_o),
  .irq_oe_o    (irq_oe_o),
  .dp_rst_o    (dp_rst_o),
  .stat_a      (stat_a_q),
  .stat_b      (stat_b_q),
  .en_a        (en_a_q),
  .en_b        (en_b_q)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [5:0] cha_evt_i = '0;
  logic [5:0] chb_evt_i = '0;
  logic       lock_i = 1'b0;
  logic       irq_o, irq_oe_o, dp_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_ctrl i_irq_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .cha_evt_i, .chb_evt_i, .lock_i, .irq_o, .irq_oe_o, .dp_rst_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [5:0] a, input logic [5:0] b);
    @(negedge clk_i);
    cha_evt_i = a; chb_evt_i = b;
    @(negedge clk_i);
    cha_evt_i = '0; chb_evt_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h04, d); chk("R2 lock flag reset value", d, 8'h01);
    rd(8'h05, d); chk("R1 chB status reset", d, 8'h00);
    rd(8'h03, d); chk("R9 chA enable reset", d, 8'h00);
    chk("R7 oe after reset", {7'b0, irq_oe_o}, 8'h00);
    chk("R8 pulse idle", {7'b0, dp_rst_o}, 8'h00);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(8'h04, 8'h01);
    rd(8'h04, d); chk("R4 clear lock flag", d, 8'h00);
    @(negedge clk_i) lock_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(8'h04, d); chk("R2 rise ignored", d, 8'h00);
    lock_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rd(8'h04, d); chk("R2 fall sets flag", d, 8'h01);
  endtask

  task automatic t_events();
    logic [7:0] d;
    wr(8'h04, 8'hFF);
    pulse(6'b101010, 6'b010101);
    repeat (2) @(negedge clk_i);
    rd(8'h04, d); chk("R1 R3 chA bits held", d, 8'hA8);
    rd(8'h05, d); chk("R1 R3 chB bits held", d, 8'h54);
    wr(8'h04, 8'h80);
    rd(8'h04, d); chk("R4 partial clear chA", d, 8'h28);
    wr(8'h05, 8'hFF);
    rd(8'h05, d); chk("R4 full clear chB", d, 8'h00);
    pulse(6'b111111, 6'b000000);
    rd(8'h04, d); chk("R1 all chA bits", d, 8'hFC);
    wr(8'h04, 8'hFF);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(6'b100000, 6'b0);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'h04; reg_wdata_i = 8'h80; cha_evt_i = 6'b100000;
    @(negedge clk_i);
    reg_we_i = 1'b0; cha_evt_i = '0;
    rd(8'h04, d); chk("R5 event beats clear", d, 8'h80);
    wr(8'h04, 8'hFF);
    rd(8'h04, d); chk("R4 clear after collision", d, 8'h00);
  endtask

  task automatic t_irq();
    pulse(6'b000001, 6'b000010);
    wr(8'h03, 8'h04);
    chk("R7 gen off oe", {7'b0, irq_oe_o}, 8'h00);
    chk("R7 gen off level", {7'b0, irq_o}, 8'h00);
    wr(8'h00, 8'h01);
    chk("R6 enabled bit raises", {7'b0, irq_o}, 8'h01);
    wr(8'h03, 8'h00);
    chk("R7 nothing enabled oe", {7'b0, irq_oe_o}, 8'h01);
    chk("R7 nothing enabled low", {7'b0, irq_o}, 8'h00);
    wr(8'h02, 8'h08);
    chk("R6 chB enable raises", {7'b0, irq_o}, 8'h01);
    wr(8'h05, 8'h08);
    chk("R6 clear drops", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_srst();
    logic [7:0] d;
    wr(8'h03, 8'h84);
    wr(8'h01, 8'h01);
    chk("R8 pulse high", {7'b0, dp_rst_o}, 8'h01);
    @(negedge clk_i);
    chk("R8 pulse one cycle", {7'b0, dp_rst_o}, 8'h00);
    rd(8'h01, d); chk("R8 cmd reads zero", d, 8'h00);
    rd(8'h03, d); chk("R8 enables kept", d, 8'h84);
    rd(8'h00, d); chk("R8 gen kept", d, 8'h01);
    rd(8'h04, d); chk("R8 status kept", d, 8'h04);
  endtask

  task automatic t_map();
    logic [7:0] d;
    rd(8'h3F, d); chk("R9 unmapped 3F", d, 8'h00);
    rd(8'h06, d); chk("R9 unmapped 06", d, 8'h00);
    wr(8'h02, 8'hFF);
    rd(8'h02, d); chk("R9 chB enable bits", d, 8'hFC);
    wr(8'h03, 8'hFF);
    rd(8'h03, d); chk("R9 chA enable bits", d, 8'hFD);
    wr(8'h00, 8'hFF);
    rd(8'h00, d); chk("R9 gen bits", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_lock();
    t_events();
    t_collide();
    t_irq();
    t_srst();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule